// File: doc/BRIEF.md
# Spanning-tree port state forwarding gate

This block sits beside the address lookup of a three-port switch whose last port carries the management CPU. Each port is configured with three control bits (transmit enable, receive enable, learning disable) that together place it in the discarding, learning or forwarding state of the rapid spanning-tree protocol. For every frame event the block takes the ingress port, the destination mask produced by the lookup and the static-entry override flag. One cycle later it presents the egress mask the frame may actually use and a strobe that allows the source address to be learned.

The CPU port itself is never gated. Frames the CPU sends may leave any port whose learning is enabled. Frames that hit a static entry with the override flag set reach the CPU even when their ingress port is blocked. A frame is never sent back out of the port it arrived on. Whenever a port's learning disable bit rises, the block queues a flush request for that port's entries in the dynamic and static address tables. It presents the requests one port at a time and holds each one until the table acknowledges it.

Top module: `stp_port_gate`

## Requirements
- R1: While rst_ni is low, and after its release until the first frame or flush event, dec_valid_o, egress_mask_o, learn_o and flush_req_o are all 0.
- R2: A frame from user port s to user port p appears in egress_mask_o when both ports are forwarding: s has receive enable 1 and p has transmit enable 1. Bit i of every mask is port i, and port 2 is the CPU port.
- R3: A frame from a user port whose receive enable is 0 (discarding or learning) and whose override flag is 0 produces an all-zero egress mask.
- R4: With the override flag 1, a frame from a non-forwarding user port still reaches the CPU port (bit 2) when that bit is in the destination mask, and reaches no user port.
- R5: A user port whose transmit enable is 0 receives no frame from another user port, even when the ingress port is forwarding.
- R6: A frame from the CPU port (frm_src_i = 2) reaches each requested user port whose learning disable is 0, and no user port whose learning disable is 1.
- R7: The egress mask never contains the frame's own ingress port, and it never contains a port outside the destination mask.
- R8: learn_o is 1 exactly when a frame was presented, its ingress is a user port, and that port's learning disable is 0. It is 0 for frames from the CPU port.
- R9: The three control bits of the CPU port have no effect on egress or learning decisions.
- R10: Two rising edges after a 0-to-1 change of a port's learning disable bit, flush_req_o is 1 with flush_port_o equal to that port's index. The request and its port stay unchanged until a cycle in which flush_ack_i is 1.
- R11: Several pending flushes are presented one at a time, lowest port index first. Each one appears on the second rising edge after the previous acknowledge. A learning disable bit that is already 1 when reset is released does not raise a flush.
- R12: dec_valid_o is 1 for exactly one cycle, the cycle after a cycle with frm_valid_i high. The decision uses the control bits sampled at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 3 | Per-port transmit enable |
| rx_en_i | input | 3 | Per-port receive enable |
| lrn_dis_i | input | 3 | Per-port learning disable |
| frm_valid_i | input | 1 | Frame event present this cycle |
| frm_src_i | input | 2 | Ingress port index (2 = CPU) |
| frm_dst_i | input | 3 | Destination mask from the lookup |
| frm_ovr_i | input | 1 | Frame matched a static entry with override set |
| dec_valid_o | output | 1 | Registered decision valid |
| egress_mask_o | output | 3 | Filtered egress mask |
| learn_o | output | 1 | Source address may be learned |
| flush_req_o | output | 1 | Flush request pending toward the table |
| flush_port_o | output | 2 | Port whose entries are to be flushed |
| flush_ack_i | input | 1 | Table has taken the flush request |

## Verification
The assertions assume that frm_src_i names an existing port, 0 to 2. They also assume that the control bits change only between frame events, so the value sampled at the decision edge is the one the property refers to. They take flush_ack_i as meaningful only while a request is shown. The stimulus keeps to these assumptions: every vector uses a source index of at most 2, control bits are applied together with the frame at the falling edge, and acknowledges are given only while flush_req_o is high, except during the table walk, where the acknowledge is tied high to drain the flushes caused by state changes.

// File: rtl/stp_gate_pkg.sv
package stp_gate_pkg;
  localparam int unsigned DEF_PORTS    = 3;
  localparam int unsigned DEF_CPU_PORT = 2;
endpackage

// File: rtl/stp_egress_filter.sv
module stp_egress_filter #(
  parameter int unsigned NP  = 3,
  parameter int unsigned CPU = 2,
  parameter int unsigned PW  = 2
) (
  input  logic [NP-1:0] tx_en_i,
  input  logic [NP-1:0] rx_en_i,
  input  logic [NP-1:0] lrn_dis_i,
  input  logic [PW-1:0] src_i,
  input  logic [NP-1:0] dst_i,
  input  logic          ovr_i,
  output logic [NP-1:0] mask_o,
  output logic          learn_o
);
  localparam int unsigned PADW = 2**PW;

  logic [PADW-1:0] rx_pad, ld_pad;
  logic [NP-1:0]   allow, src_hot;
  logic            from_cpu, src_ok, src_rx;

  assign rx_pad   = PADW'(rx_en_i);
  assign ld_pad   = PADW'(lrn_dis_i);
  assign from_cpu = (src_i == PW'(CPU));
  assign src_ok   = (32'(src_i) < NP);
  assign src_rx   = rx_pad[src_i];

  for (genvar p = 0; p < NP; p++) begin : g_port
    assign src_hot[p] = (src_i == PW'(p));
    if (p == CPU) begin : g_cpu
      // override bypasses ingress state toward the CPU only
      assign allow[p] = ~from_cpu & (src_rx | ovr_i);
    end else begin : g_user
      assign allow[p] = from_cpu ? ~lrn_dis_i[p] : (src_rx & tx_en_i[p]);
    end
  end

  assign mask_o  = src_ok ? (dst_i & allow & ~src_hot) : '0;
  assign learn_o = src_ok & ~from_cpu & ~ld_pad[src_i];
endmodule

// File: rtl/stp_flush_ctrl.sv
module stp_flush_ctrl #(
  parameter int unsigned NP = 3,
  parameter int unsigned PW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NP-1:0] lrn_dis_i,
  input  logic          ack_i,
  output logic          req_o,
  output logic [PW-1:0] port_o
);
  logic [NP-1:0] ld_q, pend_q, rise, clr;
  logic          busy_q;
  logic [PW-1:0] port_q, pick;

  assign rise = lrn_dis_i & ~ld_q;

  always_comb begin
    pick = '0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (pend_q[i]) pick = PW'(i);
    end
  end

  always_comb begin
    clr = '0;
    if (busy_q && ack_i) clr[port_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_q   <= '1; // bits already set at reset release raise no flush
      pend_q <= '0;
      busy_q <= 1'b0;
      port_q <= '0;
    end else begin
      ld_q   <= lrn_dis_i;
      pend_q <= (pend_q & ~clr) | rise;
      if (busy_q) begin
        if (ack_i) busy_q <= 1'b0;
      end else if (|pend_q) begin
        busy_q <= 1'b1;
        port_q <= pick;
      end
    end
  end

  assign req_o  = busy_q;
  assign port_o = port_q;

  // R10
  flush_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(port_o));
  // R10
  flush_port_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> 32'(port_o) < NP);
  // R11
  flush_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i |=> !req_o);
endmodule

// File: rtl/stp_port_gate.sv
module stp_port_gate
  import stp_gate_pkg::*;
#(
  parameter int unsigned NP  = DEF_PORTS,
  parameter int unsigned CPU = DEF_CPU_PORT,
  localparam int unsigned PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NP-1:0] tx_en_i,
  input  logic [NP-1:0] rx_en_i,
  input  logic [NP-1:0] lrn_dis_i,
  input  logic          frm_valid_i,
  input  logic [PW-1:0] frm_src_i,
  input  logic [NP-1:0] frm_dst_i,
  input  logic          frm_ovr_i,
  output logic          dec_valid_o,
  output logic [NP-1:0] egress_mask_o,
  output logic          learn_o,
  output logic          flush_req_o,
  output logic [PW-1:0] flush_port_o,
  input  logic          flush_ack_i
);
  logic [NP-1:0] mask_d;
  logic          learn_d;

  stp_egress_filter #(.NP(NP), .CPU(CPU), .PW(PW)) u_filter (
    .tx_en_i  (tx_en_i),
    .rx_en_i  (rx_en_i),
    .lrn_dis_i(lrn_dis_i),
    .src_i    (frm_src_i),
    .dst_i    (frm_dst_i),
    .ovr_i    (frm_ovr_i),
    .mask_o   (mask_d),
    .learn_o  (learn_d)
  );

  stp_flush_ctrl #(.NP(NP), .PW(PW)) u_flush (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lrn_dis_i(lrn_dis_i),
    .ack_i    (flush_ack_i),
    .req_o    (flush_req_o),
    .port_o   (flush_port_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o   <= 1'b0;
      egress_mask_o <= '0;
      learn_o       <= 1'b0;
    end else begin
      dec_valid_o   <= frm_valid_i;
      egress_mask_o <= frm_valid_i ? mask_d : '0;
      learn_o       <= frm_valid_i & learn_d;
    end
  end

  logic [2**PW-1:0] rx_pad_a;
  assign rx_pad_a = (2**PW)'(rx_en_i);

  // R7
  no_reflect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i && 32'(frm_src_i) < NP |=> !egress_mask_o[$past(frm_src_i)]);
  // R7
  mask_subset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i |=> (egress_mask_o & ~$past(frm_dst_i)) == '0);
  // R3
  blocked_ingress_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i && frm_src_i != PW'(CPU) && !frm_ovr_i && !rx_pad_a[frm_src_i]
    |=> egress_mask_o == '0);
  // R8
  cpu_no_learn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i && frm_src_i == PW'(CPU) |=> !learn_o);
  // R12
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_valid_i |=> !dec_valid_o && !learn_o && egress_mask_o == '0);
endmodule

// File: tb/stp_port_gate_bench.sv
`timescale 1ns/1ps
module stp_port_gate_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] tx_en = 3'b111, rx_en = 3'b111, ld = 3'b000;
  logic       fv = 1'b0, ovr = 1'b0, ack = 1'b0;
  logic [1:0] src = '0;
  logic [2:0] dst = '0;
  logic       dv, lrn, freq;
  logic [2:0] emask;
  logic [1:0] fport;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stp_port_gate u_stp_port_gate (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .rx_en_i(rx_en),
    .lrn_dis_i(ld), .frm_valid_i(fv), .frm_src_i(src), .frm_dst_i(dst),
    .frm_ovr_i(ovr), .dec_valid_o(dv), .egress_mask_o(emask), .learn_o(lrn),
    .flush_req_o(freq), .flush_port_o(fport), .flush_ack_i(ack)
  );

  // {tx, rx, ld, src, dst, ovr, exp_mask, exp_learn}
  localparam int NV = 13;
  localparam logic [18:0] VECS [NV] = '{
    {3'b111,3'b111,3'b000,2'd0,3'b111,1'b0,3'b110,1'b1}, // R2 all forwarding
    {3'b110,3'b110,3'b000,2'd0,3'b110,1'b0,3'b000,1'b1}, // R3 learning ingress
    {3'b110,3'b110,3'b000,2'd0,3'b110,1'b1,3'b100,1'b1}, // R4 override, learning
    {3'b110,3'b110,3'b001,2'd0,3'b110,1'b1,3'b100,1'b0}, // R4 override, discarding
    {3'b110,3'b110,3'b001,2'd0,3'b110,1'b0,3'b000,1'b0}, // R3 discarding ingress
    {3'b101,3'b101,3'b000,2'd0,3'b010,1'b0,3'b000,1'b1}, // R5 learning egress
    {3'b101,3'b101,3'b010,2'd0,3'b110,1'b0,3'b100,1'b1}, // R5 discarding egress
    {3'b100,3'b100,3'b010,2'd2,3'b011,1'b0,3'b001,1'b0}, // R6 cpu to L and D
    {3'b111,3'b111,3'b000,2'd2,3'b111,1'b0,3'b011,1'b0}, // R6 cpu to all
    {3'b111,3'b111,3'b000,2'd1,3'b011,1'b0,3'b001,1'b1}, // R7 no reflection
    {3'b011,3'b011,3'b100,2'd0,3'b100,1'b0,3'b100,1'b1}, // R9 cpu bits discarding
    {3'b010,3'b010,3'b101,2'd2,3'b011,1'b0,3'b010,1'b0}, // R9 cpu src, cpu bits off
    {3'b110,3'b110,3'b000,2'd1,3'b101,1'b0,3'b100,1'b1}  // R5 R8 to learning port
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1 during reset
    check(!dv && emask == 0 && !lrn && !freq, "R1", {dv, emask, lrn, freq}, 0);
    rst_n = 1'b1;
    tick(2);
    check(!dv && emask == 0 && !lrn && !freq, "R1", {dv, emask, lrn, freq}, 0);

    ack = 1'b1; // drain flushes caused by state changes in the walk
    for (int i = 0; i < NV; i++) begin
      {tx_en, rx_en, ld, src, dst, ovr} = VECS[i][18:4];
      fv = 1'b1;
      tick(1);
      fv = 1'b0;
      check(dv, "R12", dv, 1);
      check(emask == VECS[i][3:1], $sformatf("R2-vec%0d mask", i), emask, VECS[i][3:1]);
      check(lrn == VECS[i][0], $sformatf("R8 vec%0d learn", i), lrn, VECS[i][0]);
      tick(1);
      check(!dv && emask == 0, "R12", {dv, emask}, 0);
    end

    // R12: state changed one cycle later does not alter the taken decision
    {tx_en, rx_en, ld} = {3'b111, 3'b111, 3'b000};
    src = 2'd0; dst = 3'b010; ovr = 1'b0; fv = 1'b1;
    tick(1);
    fv = 1'b0; {tx_en, rx_en, ld} = {3'b100, 3'b100, 3'b011};
    #1;
    check(emask == 3'b010 && lrn, "R12", {emask, lrn}, 5);
    tick(2);
    ack = 1'b0;

    // flush tests from a fresh reset with ld already set on port 2
    rst_n = 1'b0; ld = 3'b100;
    tick(2);
    rst_n = 1'b1;
    tick(3);
    check(!freq, "R11 no flush at reset release", freq, 0);
    ld = 3'b110; // port 1 rises
    tick(1);
    check(!freq, "R10 before second edge", freq, 0);
    tick(1);
    check(freq && fport == 2'd1, "R10", {freq, fport}, 5);
    ld = 3'b000;
    tick(1);
    ld = 3'b101; // ports 0 and 2 rise while port 1 waits
    tick(3);
    check(freq && fport == 2'd1, "R10 held", {freq, fport}, 5);
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
    check(!freq, "R11 gap after ack", freq, 0);
    tick(1);
    check(freq && fport == 2'd0, "R11 lowest first", {freq, fport}, 4);
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
    tick(1);
    check(freq && fport == 2'd2, "R11 next", {freq, fport}, 6);
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
    tick(2);
    check(!freq, "R11 drained", freq, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule